// File: doc/BRIEF.md
# Reversible Counter with Shadow Recall

This block is a synchronous binary counter that can count in either direction. A change of direction is not handled by recomputing the next value. Instead, the block keeps a shadow copy of the count it held before its most recent counting step. When the requested direction differs from the direction of that step, the shadow copy becomes the new count. That copy is exactly one step back. The old count moves into the shadow at the same time. While the direction stays the same, the block steps by one like any plain counter, and it wraps modulo 2^WIDTH both upward and downward.

Reset and a parallel load both mark the shadow copy as unusable. A reversal that arrives before the next counting step therefore falls back to an ordinary computed step. The count output can be sampled on every clock edge. A terminal flag reports the end of the range for the direction currently selected.

Top module: `bidir_shadow_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `count` becomes 0 after that edge. This holds regardless of `load_en` and `cnt_en`.
- R2: When `rst` is 0 and `load_en` is 1 at an edge, `count` becomes `load_val` after that edge, whatever the value of `cnt_en`.
- R3: When `rst`, `load_en` and `cnt_en` are all 0 at an edge, `count` keeps its value.
- R4: A counting edge (`cnt_en`=1, no reset, no load) with `dn_sel`=0 that is not a reversal makes `count` one larger. All ones wraps to 0.
- R5: A non-reversing counting edge with `dn_sel`=1 makes `count` one smaller. Zero wraps to all ones.
- R6: A counting edge whose `dn_sel` differs from that of the previous counting step, with no reset or load since that step, takes the new count from the shadow copy. The result is the same value a computed step would give, including across the wrap point.
- R7: A counting edge that comes first after a reset or load uses a computed step in the selected direction, even if `dn_sel` differs from the direction used before the reset or load.
- R8: `term_flag` is 1 exactly when `dn_sel`=0 and `count` is all ones, or when `dn_sel`=1 and `count` is 0.
- R9: While the shadow copy is usable, `count` is the shadow value moved one step in the direction of the previous counting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Parallel load strobe |
| load_val | input | WIDTH | Value placed into the count on load |
| cnt_en | input | 1 | Count enable |
| dn_sel | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | WIDTH | Live count value |
| term_flag | output | 1 | Terminal count for the selected direction |

## Verification
The hardest case to reach is a reversal that lands on the wrap point, or one that comes right after a load, when the shadow copy is still unusable. From the ports it looks like any other step. The bench loads every 4-bit value and then applies every 4-step pattern of directions, so every reversal position occurs next to every load value and both wrap points. A long pseudo-random run then mixes sparse resets, loads and idle cycles with counting. This exercises reversals that follow a reset or load, and reversals that follow a chain of steps.

// File: rtl/bidir_shadow_counter.sv
module bidir_shadow_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             cnt_en,
  input  logic             dn_sel,
  output logic [WIDTH-1:0] count,
  output logic             term_flag
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] shadow_q;
  logic [WIDTH-1:0] stepped;
  logic             shadow_ok;
  logic             last_dn;
  logic             reverse;

  assign reverse   = shadow_ok && (dn_sel != last_dn);
  assign stepped   = dn_sel ? count - 1'b1 : count + 1'b1;
  assign term_flag = dn_sel ? (count == '0) : (count == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      shadow_q  <= '0;
      shadow_ok <= 1'b0;
      last_dn   <= 1'b0;
    end else if (load_en) begin
      count     <= load_val;
      shadow_ok <= 1'b0;
    end else if (cnt_en) begin
      count     <= reverse ? shadow_q : stepped;
      shadow_q  <= count;
      shadow_ok <= 1'b1;
      last_dn   <= dn_sel;
    end
  end

endmodule

module bidir_shadow_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic [WIDTH-1:0] load_val,
  input logic             cnt_en,
  input logic             dn_sel,
  input logic [WIDTH-1:0] count,
  input logic             term_flag,
  input logic [WIDTH-1:0] shadow_q,
  input logic             shadow_ok,
  input logic             last_dn
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> count == '0);

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> count == $past(load_val));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !cnt_en) |=> $stable(count));

  assert_up_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt_en && !dn_sel) |=> count == $past(count) + ONE);

  assert_down_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt_en && dn_sel) |=> count == $past(count) - ONE);

  assert_flag_at_edge_R8: assert property (@(posedge clk) disable iff (rst)
    term_flag |-> (count == '0 || count == ~'0));

  assert_shadow_one_back_R9: assert property (@(posedge clk) disable iff (rst)
    shadow_ok |-> count == (last_dn ? shadow_q - ONE : shadow_q + ONE));

endmodule

bind bidir_shadow_counter bidir_shadow_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
  .cnt_en(cnt_en), .dn_sel(dn_sel), .count(count), .term_flag(term_flag),
  .shadow_q(shadow_q), .shadow_ok(shadow_ok), .last_dn(last_dn)
);

// File: tb/bidir_shadow_counter_bench.sv
module bidir_shadow_counter_bench;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         cnt_en = 1'b0;
  logic         dn_sel = 1'b0;
  logic [W-1:0] count;
  logic         term_flag;

  int checks = 0;
  int errors = 0;
  int model = 0;
  bit m_valid = 0;
  bit m_dn = 0;

  always #10 clk = ~clk;

  bidir_shadow_counter #(.WIDTH(W)) u_bidir_shadow_counter (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .cnt_en(cnt_en), .dn_sel(dn_sel), .count(count), .term_flag(term_flag)
  );

  task automatic step(input bit r, input bit ld, input int v, input bit en, input bit dn);
    string tag;
    bit exp_flag;
    @(negedge clk);
    rst = r; load_en = ld; load_val = W'(v); cnt_en = en; dn_sel = dn;
    if (r) begin
      tag = "R1"; model = 0; m_valid = 0; m_dn = 0;
    end else if (ld) begin
      tag = "R2"; model = v % M; m_valid = 0;
    end else if (!en) begin
      tag = "R3";
    end else begin
      if (!m_valid && dn != m_dn) tag = "R7";
      else if (m_valid && dn != m_dn) tag = "R6";
      else tag = dn ? "R5" : "R4";
      model = dn ? (model + M - 1) % M : (model + 1) % M;
      m_valid = 1; m_dn = dn;
    end
    @(posedge clk);
    #2;
    checks++;
    if (int'(count) != model) begin
      errors++;
      $display("FAIL %s count actual %0d expected %0d", tag, count, model);
    end
    exp_flag = dn ? (model == 0) : (model == M - 1);
    checks++;
    if (term_flag != exp_flag) begin
      errors++;
      $display("FAIL R8 term_flag actual %0d expected %0d (count %0d dn %0d)",
               term_flag, exp_flag, count, dn);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    step(1, 1, 9, 1, 0);
    step(0, 1, 5, 1, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    step(0, 1, 15, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0);
    for (int v = 0; v < M; v++) begin
      for (int pat = 0; pat < 16; pat++) begin
        step(0, 0, 0, 1, pat[3]);
        step(0, 1, v, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, pat[k]);
      end
    end
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:0] == 8'h3C, lfsr[6:2] == 5'h11, int'(lfsr[11:8]),
           lfsr[4:2] != 3'b000, lfsr[0] ^ lfsr[9]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule